// File: doc/BRIEF.md
# NaN-aware saturating signed ALU

This block is a registered arithmetic and logic unit for N-bit two's-complement operands. It treats the most negative code (only the top bit set) as a Not-a-Number marker. The marker spreads through the arithmetic operations. Those operations clamp their results to a symmetric range that never reaches the marker. A second group of operations sees every operand as a plain bit pattern: explicit wrap-around add and subtract, bitwise operations, shifts, logical operations and comparisons.

A caller presents two operands and a 5-bit opcode together with `in_valid`. One clock edge later the result appears on `out_result`, and `out_valid` is high. When no request is presented, the result register keeps its last value. Operands are always treated as integers. The default width is 16 bits.

Top module: `nsat_alu`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_result` is 0. A request accepted with `in_valid`=1 at a clock edge sets `out_valid` to 1 and presents its result after that edge. A cycle with `in_valid`=0 clears `out_valid` and leaves `out_result` unchanged.
- R2: The NaN-aware opcodes are 0 saturating add, 1 saturating subtract, 2 saturating multiply, 3 floor division, 4 floor modulo and 5 negate (operand A only). Each returns the NaN code 0x8000 when any operand it uses equals 0x8000.
- R3: Opcodes 0, 1 and 2 with valid operands clamp the exact result to the range from -(2^(N-1)-1) to 2^(N-1)-1. They never produce 0x8000.
- R4: Opcode 3 gives the quotient rounded toward minus infinity. Opcode 4 gives the matching remainder, which takes the sign of the divisor. A zero divisor makes either opcode return 0x8000.
- R5: Opcode 6 (A+B) and opcode 7 (A-B) wrap modulo 2^N. They apply no saturation and give 0x8000 no special meaning. Negate (opcode 5) of a valid value is its two's complement.
- R6: The bitwise opcodes are 8 AND, 9 OR, 10 XOR, 11 NOT of A, 12 left shift and 13 logical right shift. For the shifts, B is taken as an unsigned amount, and any amount of N or more gives 0.
- R7: The logical opcodes are 14 AND, 15 OR, 16 XOR and 17 NOT of A. Any nonzero value counts as true, and each result is exactly 1 or 0.
- R8: The signed comparisons are 18 equal, 19 not equal, 20 less, 21 greater, 22 less-or-equal and 23 greater-or-equal. Each returns 1 or 0. The code 0x8000 equals itself and is less than every other value.
- R9: Opcodes 24 to 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 5 | Opcode |
| in_a | input | N | Operand A |
| in_b | input | N | Operand B |
| out_valid | output | 1 | Result registered from a request in the previous cycle |
| out_result | output | N | Registered result |

## Verification
Two functions of the block can apply to the same request. A NaN operand can meet an operation that would otherwise saturate, for example a NaN times a large value. A NaN dividend can also meet a zero divisor. The bench provokes both combinations, directed and through random picks that favour corner operands. It judges them by requiring the NaN code and never a clamped limit. It also pits the smallest valid value against the NaN code in the comparisons and in wrapping arithmetic. There the code must behave as a plain, most-negative bit pattern.

// File: rtl/nsat_alu_pkg.sv
package nsat_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SADD = 5'd0,  OP_SSUB = 5'd1,  OP_SMUL = 5'd2,  OP_FDIV = 5'd3,
    OP_FMOD = 5'd4,  OP_NEG  = 5'd5,  OP_WADD = 5'd6,  OP_WSUB = 5'd7,
    OP_BAND = 5'd8,  OP_BOR  = 5'd9,  OP_BXOR = 5'd10, OP_BNOT = 5'd11,
    OP_SHL  = 5'd12, OP_SHR  = 5'd13, OP_LAND = 5'd14, OP_LOR  = 5'd15,
    OP_LXOR = 5'd16, OP_LNOT = 5'd17, OP_EQ   = 5'd18, OP_NE   = 5'd19,
    OP_LT   = 5'd20, OP_GT   = 5'd21, OP_LE   = 5'd22, OP_GE   = 5'd23
  } alu_op_e;

  // opcodes whose result is NaN when an operand they use is NaN
  function automatic logic is_nan_aware(input logic [OP_W-1:0] op);
    return op <= OP_NEG;
  endfunction

  // opcodes served by the arithmetic unit
  function automatic logic is_arith_unit(input logic [OP_W-1:0] op);
    return op <= OP_WSUB;
  endfunction

  function automatic logic is_bool_result(input logic [OP_W-1:0] op);
    return (op >= OP_LAND) && (op <= OP_GE);
  endfunction
endpackage

// File: rtl/nsat_arith.sv
module nsat_arith
  import nsat_alu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [N-1:0]    a,
  input  logic [N-1:0]    b,
  output logic [N-1:0]    res,
  output logic            nan_hit,
  output logic            div_zero,
  output logic            clip_hit
);
  localparam logic [N-1:0] NAN  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] MINV = NAN + 1'b1;
  localparam logic signed [2*N-1:0] WMAX = {{N{1'b0}}, MAXV};
  localparam logic signed [2*N-1:0] WMIN = {{N{1'b1}}, MINV};

  function automatic logic [N-1:0] clamp_wide(input logic signed [2*N-1:0] v);
    if (v > WMAX)      return MAXV;
    else if (v < WMIN) return MINV;
    else               return v[N-1:0];
  endfunction

  function automatic logic out_of_range(input logic signed [2*N-1:0] v);
    return (v > WMAX) || (v < WMIN);
  endfunction

  // floor division: truncating divide, then step toward minus infinity
  function automatic logic [N-1:0] floor_divmod(input logic signed [N-1:0] x,
                                                input logic signed [N-1:0] y,
                                                input logic want_rem);
    logic signed [N-1:0] q;
    logic signed [N-1:0] r;
    q = x / y;
    r = x % y;
    if ((r != '0) && (r[N-1] != y[N-1])) begin
      q = q - 1'b1;
      r = r + y;
    end
    return want_rem ? r : q;
  endfunction

  logic signed [2*N-1:0] ax, bx, sum_w, dif_w, prd_w;
  logic [N-1:0]          b_safe;

  assign ax     = $signed({{N{a[N-1]}}, a});
  assign bx     = $signed({{N{b[N-1]}}, b});
  assign sum_w  = ax + bx;
  assign dif_w  = ax - bx;
  assign prd_w  = ax * bx;
  assign b_safe = (b == '0) ? {{(N-1){1'b0}}, 1'b1} : b;

  always_comb begin
    nan_hit  = is_nan_aware(op) && ((a == NAN) || ((b == NAN) && (op != OP_NEG)));
    div_zero = ((op == OP_FDIV) || (op == OP_FMOD)) && (b == '0);
    clip_hit = 1'b0;
    res      = '0;
    case (op)
      OP_SADD: begin res = clamp_wide(sum_w); clip_hit = out_of_range(sum_w); end
      OP_SSUB: begin res = clamp_wide(dif_w); clip_hit = out_of_range(dif_w); end
      OP_SMUL: begin res = clamp_wide(prd_w); clip_hit = out_of_range(prd_w); end
      OP_FDIV: res = floor_divmod($signed(a), $signed(b_safe), 1'b0);
      OP_FMOD: res = floor_divmod($signed(a), $signed(b_safe), 1'b1);
      OP_NEG:  res = (~a) + 1'b1;
      OP_WADD: res = a + b;
      OP_WSUB: res = a - b;
      default: res = '0;
    endcase
    if (nan_hit || div_zero) begin
      res      = NAN;
      clip_hit = 1'b0;
    end
  end
endmodule

// File: rtl/nsat_bitlogic.sv
module nsat_bitlogic
  import nsat_alu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [N-1:0]    a,
  input  logic [N-1:0]    b,
  output logic [N-1:0]    res
);
  localparam logic [N-1:0] SH_LIM = N[N-1:0];
  localparam logic [N-1:0] ONE    = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [N-1:0] as_bool(input logic t);
    return t ? ONE : '0;
  endfunction

  logic ta, tb, too_far;
  assign ta      = (a != '0);
  assign tb      = (b != '0);
  assign too_far = (b >= SH_LIM);

  always_comb begin
    case (op)
      OP_BAND: res = a & b;
      OP_BOR:  res = a | b;
      OP_BXOR: res = a ^ b;
      OP_BNOT: res = ~a;
      OP_SHL:  res = too_far ? '0 : (a << b);
      OP_SHR:  res = too_far ? '0 : (a >> b);
      OP_LAND: res = as_bool(ta && tb);
      OP_LOR:  res = as_bool(ta || tb);
      OP_LXOR: res = as_bool(ta != tb);
      OP_LNOT: res = as_bool(!ta);
      OP_EQ:   res = as_bool(a == b);
      OP_NE:   res = as_bool(a != b);
      OP_LT:   res = as_bool($signed(a) <  $signed(b));
      OP_GT:   res = as_bool($signed(a) >  $signed(b));
      OP_LE:   res = as_bool($signed(a) <= $signed(b));
      OP_GE:   res = as_bool($signed(a) >= $signed(b));
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/nsat_alu.sv
module nsat_alu
  import nsat_alu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [N-1:0]    in_a,
  input  logic [N-1:0]    in_b,
  output logic            out_valid,
  output logic [N-1:0]    out_result
);
  localparam logic [N-1:0] NAN  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] MINV = NAN + 1'b1;

  logic [N-1:0] arith_res, bits_res, next_res;
  logic         nan_hit, div_zero, clip_hit;

  nsat_arith #(.N(N)) u_arith (
    .op(in_op), .a(in_a), .b(in_b), .res(arith_res),
    .nan_hit(nan_hit), .div_zero(div_zero), .clip_hit(clip_hit)
  );

  nsat_bitlogic #(.N(N)) u_bits (
    .op(in_op), .a(in_a), .b(in_b), .res(bits_res)
  );

  assign next_res = is_arith_unit(in_op) ? arith_res : bits_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= next_res;
    end
  end

  // R1: one-cycle latency and hold while idle
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));
  // R2: NaN operand into an arithmetic opcode yields NaN
  a_r2_nan_prop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_hit) |=> (out_result == NAN));
  // R3: a clipped saturating result lands on one of the two limits
  a_r3_clip_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clip_hit) |=> ((out_result == MAXV) || (out_result == MINV)));
  // R3: saturating opcodes with valid operands never emit the NaN code
  a_r3_no_nan_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op <= OP_SMUL) && (in_a != NAN) && (in_b != NAN))
      |=> (out_result != NAN));
  // R4: zero divisor yields NaN
  a_r4_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && div_zero) |=> (out_result == NAN));
  // R7, R8: boolean results are 0 or 1
  a_r8_bool_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_bool_result(in_op)) |=> (out_result[N-1:1] == '0));
endmodule

// File: tb/nsat_alu_test.sv
module nsat_alu_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [15:0] NAN = 16'h8000;
  localparam logic [15:0] MAXV = 16'h7FFF;
  localparam logic [15:0] MINV = 16'h8001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] in_op = '0;
  logic [15:0] in_a = '0, in_b = '0;
  logic out_valid;
  logic [15:0] out_result;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nsat_alu #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [15:0] sat(input int v);
    if (v > 32767) return MAXV;
    if (v < -32767) return MINV;
    return v[15:0];
  endfunction

  function automatic logic [15:0] bl(input bit t);
    return t ? 16'd1 : 16'd0;
  endfunction

  function automatic logic [15:0] model(input logic [4:0] op, input logic [15:0] a,
                                        input logic [15:0] b);
    int x, y, r, q;
    x = int'($signed(a));
    y = int'($signed(b));
    if (op <= 5 && (a == NAN || (b == NAN && op != 5))) return NAN;
    case (op)
      0: return sat(x + y);
      1: return sat(x - y);
      2: return sat(x * y);
      3, 4: begin
        if (y == 0) return NAN;
        r = x % y;
        if (r != 0 && ((r < 0) != (y < 0))) r = r + y;
        q = (x - r) / y;
        return (op == 3) ? q[15:0] : r[15:0];
      end
      5: return 16'(-x);
      6: return a + b;
      7: return a - b;
      8: return a & b;
      9: return a | b;
      10: return a ^ b;
      11: return ~a;
      12: return (b >= 16) ? 16'd0 : 16'(a << b);
      13: return (b >= 16) ? 16'd0 : 16'(a >> b);
      14: return bl(x != 0 && y != 0);
      15: return bl(x != 0 || y != 0);
      16: return bl((x != 0) != (y != 0));
      17: return bl(x == 0);
      18: return bl(x == y);
      19: return bl(x != y);
      20: return bl(x < y);
      21: return bl(x > y);
      22: return bl(x <= y);
      23: return bl(x >= y);
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    if (op <= 1 || op == 2) return "R3";
    if (op == 3 || op == 4) return "R4";
    if (op == 5 || op == 6 || op == 7) return "R5";
    if (op <= 13) return "R6";
    if (op <= 17) return "R7";
    if (op <= 23) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [4:0] op,
                        input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    #1;
    if (out_valid !== 1'b1) check("R1", {15'd0, out_valid}, 16'd1);
    check(tag, out_result, model(op, a, b));
  endtask

  function automatic logic [15:0] pick_operand();
    logic [15:0] pool [10] = '{16'h0000, 16'h0001, 16'hFFFF, NAN, MAXV, MINV,
                                16'h0002, 16'h0010, 16'hFFFE, 16'h4000};
    if ($urandom_range(3) == 0) return pool[$urandom_range(9)];
    return 16'($urandom());
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 2);
    #1;
    check("R1", {15'd0, out_valid}, 16'd0);
    check("R1", out_result, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: saturation at both limits, never the NaN code
    run_op("R3", 5'd0, MAXV, 16'd1);
    run_op("R3", 5'd1, MINV, 16'd1);
    run_op("R3", 5'd2, 16'd300, 16'd300);
    run_op("R3", 5'd2, 16'd300, 16'hFED4);
    // R2: NaN propagation, including overlap with saturation and zero divisor
    run_op("R2", 5'd0, NAN, 16'd0);
    run_op("R2", 5'd2, NAN, MAXV);
    run_op("R2", 5'd3, NAN, 16'd0);
    run_op("R2", 5'd1, 16'd5, NAN);
    run_op("R2", 5'd5, NAN, 16'd7);
    // R4: floor division and modulo
    run_op("R4", 5'd3, 16'hFFF9, 16'd2);
    run_op("R4", 5'd4, 16'hFFF9, 16'd2);
    run_op("R4", 5'd4, 16'd7, 16'hFFFE);
    run_op("R4", 5'd3, 16'd7, 16'd0);
    run_op("R4", 5'd4, 16'd7, 16'd0);
    run_op("R4", 5'd3, MINV, 16'hFFFF);
    // R5: wrap-around ignores saturation and NaN; negate
    run_op("R5", 5'd6, MAXV, 16'd1);
    run_op("R5", 5'd7, NAN, 16'd1);
    run_op("R5", 5'd5, 16'd5, 16'd0);
    // R6: bitwise and shifts
    run_op("R6", 5'd8, NAN, 16'hFFFF);
    run_op("R6", 5'd12, 16'd1, 16'd16);
    run_op("R6", 5'd13, NAN, 16'd15);
    run_op("R6", 5'd11, NAN, 16'd0);
    // R7: logical ops treat NaN as true
    run_op("R7", 5'd14, NAN, 16'd1);
    run_op("R7", 5'd17, 16'd0, 16'd0);
    run_op("R7", 5'd16, 16'd4, 16'd9);
    // R8: NaN ordering
    run_op("R8", 5'd20, NAN, MINV);
    run_op("R8", 5'd18, NAN, NAN);
    run_op("R8", 5'd23, MINV, NAN);
    // R9: undefined opcodes
    run_op("R9", 5'd31, 16'd3, 16'd4);
    run_op("R9", 5'd24, MAXV, MAXV);

    // R1: idle cycle clears valid and holds result
    held = out_result;
    @(negedge clk);
    in_valid = 1'b0; in_op = 5'd0; in_a = 16'd1; in_b = 16'd1;
    @(posedge clk);
    #1;
    check("R1", {15'd0, out_valid}, 16'd0);
    check("R1", out_result, held);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] op;
      logic [15:0] a, b;
      op = 5'($urandom_range(31));
      a = pick_operand();
      b = pick_operand();
      if (op <= 5 && (a == NAN || (b == NAN && op != 5)))
        run_op("R2", op, a, b);
      else
        run_op(tag_of(op), op, a, b);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule